// File: doc/BRIEF.md
# Multi-Master I2C Write Engine with Arbitration and Bus Wait

This block is the transmit side of an I2C master that shares a two-wire bus with other masters. Software loads a 7-bit target address, a direction bit and one data byte, then pulses a start request. The engine tracks START and STOP conditions on the wires to keep an internal busy/free state. If the bus is busy, it holds the request until the bus is free and the master function is enabled. It then issues START, the address frame, the data byte and STOP. After each byte it leaves SDA released for the acknowledge slot.

On every data bit the engine compares the level it meant to put on SDA with the level it samples at the end of the SCL high phase. If it released SDA to send a one and finds the line low, it has lost arbitration. It releases both wires in that cycle, raises a sticky arbitration-lost flag together with transfer-complete, and goes quiet. It makes no retry and never becomes a slave. A new request after a loss waits for the winning master's STOP. The bus busy/free state is never output.

Both wires are open-drain. The block outputs drive-low enables and takes back the sampled wire levels, which pass through a two-flop synchronizer. SCL timing comes from a programmable half-period in clock cycles, with equal high and low halves.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset both drive-low enables are 0 and the done, arbitration-lost and NACK flags are 0.
- R2: A transfer begins with START, meaning SDA is pulled low while SCL is released. Then come the 7 address bits, MSB first, and the direction bit (0 = write). The engine changes SDA only while it holds SCL low.
- R3: A write transfer (direction 0) whose address is acknowledged continues as follows: the data byte MSB first, a released SDA during its acknowledge slot, then STOP, meaning SDA is released while SCL is high. done_o rises in the same cycle that SDA is released for STOP.
- R4: A transfer with direction 1 sends only the address frame. After an acknowledged address it issues STOP with no further byte.
- R5: SDA found high in any acknowledge slot is a NACK. The engine then issues STOP and sets nack_o and done_o. nack_o and arb_lost_o are never 1 together.
- R6: A request made while the bus is busy is held. A START by another master, with no STOP since, makes the bus busy. The engine issues its START only after a STOP has been seen on the bus.
- R7: While master_en is 0, a held request does not start. It starts once master_en is 1 and the bus is free.
- R8: A lost bit is one the engine sends as 1 (SDA released) but samples as 0 at the end of the SCL high phase. On a lost bit both drive-low enables go to 0 in the same cycle that arb_lost_o and done_o rise. After that the engine drives nothing and makes no retry.
- R9: After arbitration loss, a new request waits until a STOP appears on the bus.
- R10: A request is accepted only when the engine is idle with no request held; any other request is ignored. Issuing START clears done_o, arb_lost_o and nack_o.
- R11: Each SCL high phase and each SCL low phase driven by the engine lasts exactly div_half clock cycles. div_half must be at least 4 and held constant during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Enables starting held requests |
| div_half | input | DIVW | SCL half-period in clock cycles (at least 4) |
| cmd_start | input | 1 | One-cycle transfer request |
| cmd_addr | input | 7 | Target address |
| cmd_rw | input | 1 | Direction bit sent after the address (1 = read) |
| cmd_data | input | 8 | Byte sent after an acknowledged write address |
| scl_in | input | 1 | Sampled SCL wire level |
| sda_in | input | 1 | Sampled SDA wire level |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_low_o | output | 1 | Pull SDA low when 1 |
| done_o | output | 1 | Sticky transfer complete |
| arb_lost_o | output | 1 | Sticky arbitration lost |
| nack_o | output | 1 | Sticky NACK received |

## Verification
A request accepted at one clock edge on a free bus issues START at the next edge. There done_o falls and sda_low_o rises. After a STOP by another master, START follows within about four cycles: two synchronizer stages, the bus-state register and the sequencer. Each SCL phase then lasts exactly div_half cycles, and the bench measures this as a count of falling clock edges while SCL is high. On a lost bit, the release of both wires and arb_lost_o appear in the same sample, and done_o rises with the SDA release of STOP. The bench samples these together on the falling clock edge. It decodes bytes from the wires with its own bus monitor, and waits on flags only through bounded loops.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_LOW,
    PH_HIGH,
    PH_STOP_LOW,
    PH_STOP_HIGH
  } phase_t;

  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;

  // A bit is lost when the engine released SDA (sent one) but saw it low.
  function automatic logic lost_bit(input logic sent_one, input logic seen_level);
    return sent_one & ~seen_level;
  endfunction

  // Phases in which the engine holds SCL low.
  function automatic logic scl_pulled(input phase_t ph);
    return (ph == PH_LOW) || (ph == PH_STOP_LOW);
  endfunction

  // First frame on the wire: address followed by the direction bit.
  function automatic logic [BYTE_W-1:0] addr_frame(input logic [ADDR_W-1:0] a,
                                                   input logic rw);
    return {a, rw};
  endfunction

endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  // Idle bus level is high on both wires, so reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_arb_busmon.sv
module i2c_arb_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy
);

  logic scl_p, sda_p;
  logic start_ev, stop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // SDA edge while SCL stays high: falling = START, rising = STOP.
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy <= 1'b0;
    else if (start_ev) busy <= 1'b1;
    else if (stop_ev)  busy <= 1'b0;
  end

  assert_busy_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy);

  assert_free_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !busy);

endmodule

// File: rtl/i2c_arb_halftick.sv
module i2c_arb_halftick #(
  parameter int unsigned DIVW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div_half,
  output logic            tick
);

  logic [DIVW-1:0] cnt_q;

  assign tick = run && (cnt_q == div_half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // Counter stays inside one half-period while a transfer runs.
  assert_half_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div_half));

endmodule

// File: rtl/i2c_arb_engine.sv
module i2c_arb_engine
  import i2c_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_rw,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              sda_s,
  input  logic              bus_busy,
  input  logic              tick,
  output logic              run,
  output logic              scl_low,
  output logic              sda_low,
  output logic              done,
  output logic              arb_lost,
  output logic              nack
);

  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

  phase_t            ph_q, ph_n;
  logic              pend_q, pend_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              rw_q, rw_n;
  logic [BYTE_W-1:0] data_q, data_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [3:0]        bit_q, bit_n;
  logic              byte_q, byte_n;
  logic              scl_q, sda_q, sda_n, scl_n, sda_want;
  logic              done_q, done_n, arb_q, arb_n, nack_q, nack_n;

  // Named internal events for the assertions.
  logic start_issue, loss_ev, stop_issue;

  always_comb begin
    ph_n   = ph_q;
    pend_n = pend_q;
    addr_n = addr_q;
    rw_n   = rw_q;
    data_n = data_q;
    sh_n   = sh_q;
    bit_n  = bit_q;
    byte_n = byte_q;
    done_n = done_q;
    arb_n  = arb_q;
    nack_n = nack_q;
    start_issue = 1'b0;
    loss_ev     = 1'b0;
    stop_issue  = 1'b0;

    if (cmd_start && (ph_q == PH_IDLE) && !pend_q) begin
      pend_n = 1'b1;
      addr_n = cmd_addr;
      rw_n   = cmd_rw;
      data_n = cmd_data;
    end

    case (ph_q)
      PH_IDLE: begin
        if (pend_q && master_en && !bus_busy) begin
          ph_n   = PH_START;
          pend_n = 1'b0;
          done_n = 1'b0;
          arb_n  = 1'b0;
          nack_n = 1'b0;
          start_issue = 1'b1;
        end
      end
      PH_START: begin
        if (tick) begin
          ph_n   = PH_LOW;
          sh_n   = addr_frame(addr_q, rw_q);
          bit_n  = '0;
          byte_n = 1'b0;
        end
      end
      PH_LOW: begin
        if (tick) ph_n = PH_HIGH;
      end
      PH_HIGH: begin
        if (tick) begin
          if (bit_q != ACK_SLOT) begin
            if (lost_bit(sh_q[BYTE_W-1], sda_s)) begin
              loss_ev = 1'b1;
              ph_n    = PH_IDLE;
              arb_n   = 1'b1;
              done_n  = 1'b1;
            end else begin
              sh_n  = sh_q << 1;
              bit_n = bit_q + 4'd1;
              ph_n  = PH_LOW;
            end
          end else if (sda_s) begin
            nack_n = 1'b1;
            ph_n   = PH_STOP_LOW;
          end else if (!byte_q && !rw_q) begin
            sh_n   = data_q;
            byte_n = 1'b1;
            bit_n  = '0;
            ph_n   = PH_LOW;
          end else begin
            ph_n = PH_STOP_LOW;
          end
        end
      end
      PH_STOP_LOW: begin
        if (tick) ph_n = PH_STOP_HIGH;
      end
      PH_STOP_HIGH: begin
        if (tick) begin
          ph_n       = PH_IDLE;
          done_n     = 1'b1;
          stop_issue = 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase

    case (ph_n)
      PH_START, PH_STOP_LOW, PH_STOP_HIGH: sda_want = 1'b1;
      PH_LOW, PH_HIGH: sda_want = (bit_n != ACK_SLOT) && !sh_n[BYTE_W-1];
      default: sda_want = 1'b0;
    endcase

    scl_n = scl_pulled(ph_n);
    // Hold SDA for the cycle in which SCL first goes low.
    sda_n = (scl_n && !scl_q) ? sda_q : sda_want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      pend_q <= 1'b0;
      addr_q <= '0;
      rw_q   <= 1'b0;
      data_q <= '0;
      sh_q   <= '0;
      bit_q  <= '0;
      byte_q <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
      arb_q  <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      pend_q <= pend_n;
      addr_q <= addr_n;
      rw_q   <= rw_n;
      data_q <= data_n;
      sh_q   <= sh_n;
      bit_q  <= bit_n;
      byte_q <= byte_n;
      scl_q  <= scl_n;
      sda_q  <= sda_n;
      done_q <= done_n;
      arb_q  <= arb_n;
      nack_q <= nack_n;
    end
  end

  assign run      = (ph_q != PH_IDLE);
  assign scl_low  = scl_q;
  assign sda_low  = sda_q;
  assign done     = done_q;
  assign arb_lost = arb_q;
  assign nack     = nack_q;

  assert_release_on_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loss_ev |=> (!scl_q && !sda_q && arb_q && done_q));

  assert_start_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_q) && !scl_q) |-> $past(!bus_busy && master_en));

  assert_sda_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HIGH && $past(ph_q) == PH_HIGH) |-> $stable(sda_q));

  assert_ack_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HIGH && bit_q == ACK_SLOT) |-> !sda_q);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_q, nack_q}));

  assert_done_with_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_issue |=> (done_q && !sda_q && !scl_q));

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_issue |=> (!done_q && !arb_q && !nack_q));

endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
  import i2c_arb_pkg::*;
#(
  parameter int unsigned DIVW      = 12,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic [DIVW-1:0]   div_half,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_rw,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              done_o,
  output logic              arb_lost_o,
  output logic              nack_o
);

  logic [1:0] wires_s;
  logic       bus_busy, run, tick;

  i2c_arb_sync #(.STAGES(SYNC_DEPTH), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     (wires_s)
  );

  i2c_arb_busmon u_busmon (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_s (wires_s[1]),
    .sda_s (wires_s[0]),
    .busy  (bus_busy)
  );

  i2c_arb_halftick #(.DIVW(DIVW)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div_half (div_half),
    .tick     (tick)
  );

  i2c_arb_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .cmd_start (cmd_start),
    .cmd_addr  (cmd_addr),
    .cmd_rw    (cmd_rw),
    .cmd_data  (cmd_data),
    .sda_s     (wires_s[0]),
    .bus_busy  (bus_busy),
    .tick      (tick),
    .run       (run),
    .scl_low   (scl_low_o),
    .sda_low   (sda_low_o),
    .done      (done_o),
    .arb_lost  (arb_lost_o),
    .nack      (nack_o)
  );

endmodule

// File: tb/i2c_arb_master_tb.sv
module i2c_arb_master_tb;

  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b1;
  logic cmd_start = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic cmd_rw = 1'b0;
  logic [7:0] cmd_data = '0;
  logic scl_low_o, sda_low_o, done_o, arb_lost_o, nack_o;

  logic tb_ack_low = 1'b0;
  logic tb_mst_low = 1'b0;
  logic arb_on = 1'b0, arb_trig = 1'b0;
  logic ack_a_cfg = 1'b1, ack_d_cfg = 1'b1;
  int   arb_at = 2;

  wire bus_scl = !scl_low_o;
  wire bus_sda = !(sda_low_o | tb_ack_low | tb_mst_low | (arb_on & arb_trig));

  always #10 clk = ~clk;

  i2c_arb_master #(.DIVW(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .div_half(12'(DIV)),
    .cmd_start(cmd_start), .cmd_addr(cmd_addr), .cmd_rw(cmd_rw), .cmd_data(cmd_data),
    .scl_in(bus_scl), .sda_in(bus_sda),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .done_o(done_o),
    .arb_lost_o(arb_lost_o), .nack_o(nack_o)
  );

  // Bus monitor: decodes bytes and START/STOP from the wires.
  int bitcnt = 0, nb = 0, starts = 0, stops = 0;
  logic [7:0] cur = '0;
  logic [7:0] blog [4];
  logic pscl = 1'b1, psda = 1'b1;

  always @(bus_scl or bus_sda) begin
    if (bus_scl && pscl && psda && !bus_sda) begin
      bitcnt = 0; nb = 0; starts++;
    end else if (bus_scl && pscl && !psda && bus_sda) begin
      stops++;
    end else if (bus_scl && !pscl) begin
      if (bitcnt < 8) begin
        cur = {cur[6:0], bus_sda};
        bitcnt++;
      end else begin
        if (nb < 4) blog[nb] = cur;
        nb++;
        bitcnt = 0;
      end
    end
    pscl = bus_scl;
    psda = bus_sda;
  end

  // Acknowledging slave and competing master, acting after SCL falls.
  always @(negedge bus_scl) begin
    #40;
    if (bitcnt == 8) tb_ack_low = (nb == 0) ? ack_a_cfg : ack_d_cfg;
    else             tb_ack_low = 1'b0;
    arb_trig = arb_on && (arb_trig || (nb == 0 && bitcnt == arb_at));
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic request(input logic [6:0] a, input logic rw, input logic [7:0] d);
    @(negedge clk);
    cmd_addr = a; cmd_rw = rw; cmd_data = d; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_done(input logic val, input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done_o == val) begin ok = 1; break; end
    end
  endtask

  // Vector: {addr[6:0], rw, data[7:0], ack_addr, ack_data}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {7'h3A, 1'b0, 8'hC5, 1'b1, 1'b1},
    {7'h7F, 1'b0, 8'h00, 1'b1, 1'b1},
    {7'h01, 1'b1, 8'hFF, 1'b1, 1'b1},
    {7'h55, 1'b0, 8'hAA, 1'b0, 1'b1},
    {7'h2C, 1'b0, 8'h81, 1'b1, 1'b0},
    {7'h00, 1'b0, 8'hFF, 1'b1, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok;
    int n, st0, drv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!scl_low_o && !sda_low_o, "R1 lines released", {scl_low_o, sda_low_o}, 0);
    check(!done_o && !arb_lost_o && !nack_o, "R1 flags clear",
          {done_o, arb_lost_o, nack_o}, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [6:0] a; logic rw; logic [7:0] d; logic aa, ad;
      int exp_nb; logic exp_nack;
      {a, rw, d, aa, ad} = VEC[v];
      ack_a_cfg = aa; ack_d_cfg = ad;
      exp_nb   = (!aa || rw) ? 1 : 2;
      exp_nack = !aa || (!rw && !ad);
      request(a, rw, d);
      wait_done(1'b0, 40, ok);
      check(ok, "R10 done cleared at START", done_o, 0);
      wait_done(1'b1, 2000, ok);
      check(ok, "R3 done raised", done_o, 1);
      repeat (4) @(negedge clk);
      check(blog[0] == {a, rw}, "R2 address frame", blog[0], {a, rw});
      check(nb == exp_nb, "R4 byte count", nb, exp_nb);
      if (exp_nb == 2) check(blog[1] == d, "R3 data byte", blog[1], d);
      check(nack_o == exp_nack, "R5 nack flag", nack_o, exp_nack);
      check(!arb_lost_o, "R5 no arbitration loss", arb_lost_o, 0);
      check(!scl_low_o && !sda_low_o && bus_sda, "R3 STOP left bus released",
            {scl_low_o, sda_low_o}, 0);
    end
    ack_a_cfg = 1'b1; ack_d_cfg = 1'b1;

    // R11 half-period length
    request(7'h66, 1'b0, 8'h5A);
    @(posedge bus_scl);
    n = 0;
    @(negedge clk);
    while (bus_scl) begin n++; @(negedge clk); end
    check(n == DIV, "R11 SCL high length", n, DIV);
    wait_done(1'b1, 2000, ok);
    check(ok && blog[1] == 8'h5A, "R11 transfer completes", blog[1], 8'h5A);

    // R10 request during a transfer is ignored
    request(7'h12, 1'b0, 8'h34);
    wait_done(1'b0, 40, ok);
    request(7'h6E, 1'b0, 8'h99);
    wait_done(1'b1, 2000, ok);
    repeat (4) @(negedge clk);
    check(blog[0] == {7'h12, 1'b0}, "R10 first command kept", blog[0], {7'h12, 1'b0});
    st0 = starts;
    repeat (300) @(negedge clk);
    check(starts == st0 && done_o, "R10 ignored command never starts", starts, st0);

    // R7 master disabled holds request
    master_en = 1'b0;
    request(7'h44, 1'b0, 8'h11);
    st0 = starts;
    repeat (80) @(negedge clk);
    check(starts == st0 && done_o, "R7 no START while disabled", starts, st0);
    master_en = 1'b1;
    wait_done(1'b0, 40, ok);
    check(ok, "R7 start after enable", done_o, 0);
    wait_done(1'b1, 2000, ok);
    repeat (4) @(negedge clk);
    check(blog[0] == {7'h44, 1'b0}, "R7 held address sent", blog[0], {7'h44, 1'b0});

    // R6 busy bus: another master's START, then STOP
    tb_mst_low = 1'b1;
    repeat (20) @(negedge clk);
    request(7'h21, 1'b0, 8'hE7);
    drv = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      drv |= int'(scl_low_o | sda_low_o);
    end
    check(drv == 0 && done_o, "R6 no drive while busy", drv, 0);
    tb_mst_low = 1'b0;
    wait_done(1'b0, 20, ok);
    check(ok, "R6 START soon after STOP", done_o, 0);
    wait_done(1'b1, 2000, ok);
    repeat (4) @(negedge clk);
    check(blog[1] == 8'hE7, "R6 deferred transfer data", blog[1], 8'hE7);

    // R8 arbitration loss on address bit 2 (a one from 7'h50)
    arb_at = 2; arb_on = 1'b1;
    request(7'h50, 1'b0, 8'h0F);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (arb_lost_o) begin ok = 1; break; end
    end
    check(ok, "R8 arbitration lost flagged", arb_lost_o, 1);
    check(!scl_low_o && !sda_low_o, "R8 lines released with flag",
          {scl_low_o, sda_low_o}, 0);
    check(done_o && !nack_o, "R8 done set nack clear", {done_o, nack_o}, 2'b10);
    check(bitcnt == 3, "R8 stopped after losing bit", bitcnt, 3);
    drv = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      drv |= int'(scl_low_o | sda_low_o);
    end
    check(drv == 0, "R8 no retry after loss", drv, 0);

    // R9 new request waits for the winner's STOP
    request(7'h0B, 1'b0, 8'hC3);
    drv = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      drv |= int'(scl_low_o | sda_low_o);
    end
    check(drv == 0 && arb_lost_o, "R9 waits for STOP", drv, 0);
    arb_on = 1'b0;
    wait_done(1'b0, 20, ok);
    check(ok && !arb_lost_o, "R10 START clears arbitration flag", arb_lost_o, 0);
    wait_done(1'b1, 2000, ok);
    repeat (4) @(negedge clk);
    check(blog[0] == {7'h0B, 1'b0} && blog[1] == 8'hC3, "R9 retried transfer",
          blog[1], 8'hC3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule